// File: doc/BRIEF.md
# Packed-Word Colour Palette Loader

This block holds a 256-entry colour table of 24-bit RGB values. A host fills the table through two 32-bit registers: an index register at word offset 0 and a data port at word offset 1. Every data word carries four colour component bytes, not one whole entry. One RGB entry therefore often begins in one word and ends in the next.

The loader walks through the bytes of each data word in stream order. It keeps the red and green bytes of an entry that is not yet complete in holding registers. It writes the entry into the table when the blue byte arrives, then moves on to the next index. The usual host sequence writes an index that is a multiple of four, then three data words that rebuild four entries. To change one entry, the host rewrites the whole aligned group of four.

The display side uses a separate lookup port. A pixel index goes in, and the matching RGB value comes out of a register one cycle later. A lookup can share a cycle with a load.

Top module: `pal_loader_top`

## Requirements
- R1: While reset is asserted, `lk_rgb` reads zero. Once reset is released, the load index is 0, the next expected component is red, and the holding registers are clear. Data words written without a prior index write therefore start filling entry 0 with its red byte.
- R2: A write with `wr_sel`=0 loads `wr_data[7:0]` as the load index. It also discards any red or green bytes that are held, so the next data byte is taken as red.
- R3: Within a data word (`wr_sel`=1), the byte in bits 31:24 is the first in stream order, then bits 23:16, then 15:8, and bits 7:0 last.
- R4: Component bytes are taken as red, green, blue for one entry after another. Three data words written after an index write of 4k fill entries 4k to 4k+3. The stored entry is {red, green, blue}, with red in bits 23:16 of `lk_rgb`.
- R5: Red and green bytes that arrive in one data word are kept across writes and joined with the blue byte from a later word.
- R6: An entry is written to the table only when its blue byte arrives, and the load index then increases by one. After entry 255 the index wraps to 0, so a longer stream continues at entry 0.
- R7: `lk_rgb` shows the table entry at `lk_idx` as sampled on the previous rising clock edge.
- R8: Suppose a lookup and a data write that completes the same entry fall in the same cycle. The lookup returns the old value, and a lookup in a later cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_sel | input | 1 | Register select: 0 = index register, 1 = data port |
| wr_data | input | 32 | Write data: the index in bits 7:0, or four component bytes |
| lk_idx | input | 8 | Pixel index for lookup |
| lk_rgb | output | 24 | Registered RGB of the looked-up entry {R,G,B} |

## Verification
The bench loads all 256 entries with an arithmetic pattern as one continuous stream and reads every entry back, so a byte-order or component-order slip would corrupt whole regions of the table. It runs the stream past entry 255; an index that saturated or did not wrap would leave entries 0 to 3 stale. It cuts groups short after one and after two words and then rewrites the index. A loader that kept held bytes would then write shifted colours and touch entries that the bench expects to be left alone. Finally, it reads an entry in the same cycle that entry is completed: a write-first table would return the new colour one lookup too early.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Which colour component the next stream byte fills.
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  // Number of entries completed by one word of BPW bytes when the stream
  // is at phase ph before the word.
  function automatic int commits_per_word(input int ph, input int bpw);
    return (ph + bpw) / 3;
  endfunction

endpackage

// File: rtl/pal_rst_sync.sv
module pal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pal_unpack.sv
module pal_unpack
  import pal_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int COMP_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          addr_we,
  input  logic                          data_we,
  input  logic [DATA_W-1:0]             wdata,
  output logic [((DATA_W/COMP_W)+2)/3-1:0] commit_vld,
  output logic [((DATA_W/COMP_W)+2)/3-1:0][IDX_W-1:0]    commit_idx,
  output logic [((DATA_W/COMP_W)+2)/3-1:0][3*COMP_W-1:0] commit_rgb,
  output logic [IDX_W-1:0]              idx_o,
  output logic [1:0]                    phase_o
);

  localparam int BPW     = DATA_W / COMP_W;
  localparam int NCOMMIT = (BPW + 2) / 3;
  localparam int SLOT_W  = (NCOMMIT > 1) ? $clog2(NCOMMIT) : 1;

  // State registers
  logic [IDX_W-1:0]  idx_q,   idx_d;
  phase_e            phase_q, phase_d;
  logic [COMP_W-1:0] red_q,   red_d;
  logic [COMP_W-1:0] grn_q,   grn_d;
  logic              state_en;

  // Walk variables for the byte loop
  logic [IDX_W-1:0]  ix_c;
  phase_e            ph_c;
  logic [COMP_W-1:0] r_c;
  logic [COMP_W-1:0] g_c;
  logic [COMP_W-1:0] byte_c;
  logic [SLOT_W-1:0] slot_c;

  // Byte walk: first byte in the top lane, last byte in the bottom lane.
  always_comb begin
    ix_c       = idx_q;
    ph_c       = phase_q;
    r_c        = red_q;
    g_c        = grn_q;
    byte_c     = '0;
    slot_c     = '0;
    commit_vld = '0;
    commit_idx = '0;
    commit_rgb = '0;
    for (int b = 0; b < BPW; b++) begin
      byte_c = wdata[DATA_W-1-b*COMP_W -: COMP_W];
      unique case (ph_c)
        PH_RED: begin
          r_c  = byte_c;
          ph_c = PH_GRN;
        end
        PH_GRN: begin
          g_c  = byte_c;
          ph_c = PH_BLU;
        end
        default: begin
          commit_vld[slot_c] = data_we;
          commit_idx[slot_c] = ix_c;
          commit_rgb[slot_c] = {r_c, g_c, byte_c};
          slot_c             = slot_c + 1'b1;
          ix_c               = ix_c + 1'b1;
          ph_c               = PH_RED;
        end
      endcase
    end
  end

  // Next state
  always_comb begin
    state_en = addr_we | data_we;
    if (addr_we) begin
      idx_d   = wdata[IDX_W-1:0];
      phase_d = PH_RED;
      red_d   = '0;
      grn_d   = '0;
    end else begin
      idx_d   = ix_c;
      phase_d = ph_c;
      red_d   = r_c;
      grn_d   = g_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
      red_q   <= '0;
      grn_q   <= '0;
    end else if (state_en) begin
      idx_q   <= idx_d;
      phase_q <= phase_d;
      red_q   <= red_d;
      grn_q   <= grn_d;
    end
  end

  assign idx_o   = idx_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int IDX_W = 8,
  parameter int RGB_W = 24,
  parameter int NWP   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NWP-1:0]              we,
  input  logic [NWP-1:0][IDX_W-1:0]   waddr,
  input  logic [NWP-1:0][RGB_W-1:0]   wdata,
  input  logic [IDX_W-1:0]            raddr,
  output logic [RGB_W-1:0]            rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [RGB_W-1:0] mem_q [DEPTH];
  logic [RGB_W-1:0] rd_q;

  // Table storage: no reset, write ports never share an address in a cycle.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NWP; p++) begin
      if (we[p]) begin
        mem_q[waddr[p]] <= wdata[p];
      end
    end
  end

  // Registered lookup, reads the value held before this edge's writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= mem_q[raddr];
    end
  end

  assign rdata = rd_q;

endmodule

// File: rtl/pal_loader_top.sv
module pal_loader_top #(
  parameter int DATA_W = 32,
  parameter int COMP_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_sel,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [IDX_W-1:0]      lk_idx,
  output logic [3*COMP_W-1:0]   lk_rgb
);

  localparam int BPW     = DATA_W / COMP_W;
  localparam int NCOMMIT = (BPW + 2) / 3;
  localparam int RGB_W   = 3 * COMP_W;

  logic                             rst_n_s;
  logic                             addr_we;
  logic                             data_we;
  logic [NCOMMIT-1:0]               commit_vld;
  logic [NCOMMIT-1:0][IDX_W-1:0]    commit_idx;
  logic [NCOMMIT-1:0][RGB_W-1:0]    commit_rgb;
  logic [IDX_W-1:0]                 load_idx;
  logic [1:0]                       load_phase;

  pal_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign addr_we = wr_en & ~wr_sel;
  assign data_we = wr_en &  wr_sel;

  pal_unpack #(
    .DATA_W (DATA_W),
    .COMP_W (COMP_W),
    .IDX_W  (IDX_W)
  ) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .addr_we    (addr_we),
    .data_we    (data_we),
    .wdata      (wr_data),
    .commit_vld (commit_vld),
    .commit_idx (commit_idx),
    .commit_rgb (commit_rgb),
    .idx_o      (load_idx),
    .phase_o    (load_phase)
  );

  pal_ram #(
    .IDX_W (IDX_W),
    .RGB_W (RGB_W),
    .NWP   (NCOMMIT)
  ) u_ram (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (commit_vld),
    .waddr (commit_idx),
    .wdata (commit_rgb),
    .raddr (lk_idx),
    .rdata (lk_rgb)
  );

endmodule

// File: rtl/pal_loader_chk.sv
module pal_loader_chk #(
  parameter int DATA_W  = 32,
  parameter int COMP_W  = 8,
  parameter int IDX_W   = 8,
  parameter int NCOMMIT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               wr_sel,
  input logic [DATA_W-1:0]  wr_data,
  input logic [IDX_W-1:0]   load_idx,
  input logic [1:0]         load_phase,
  input logic [NCOMMIT-1:0] commit_vld
);

  localparam int BPW = DATA_W / COMP_W;

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    load_phase != 2'd3); // R4

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (load_idx == $past(wr_data[IDX_W-1:0]) && load_phase == 2'd0)); // R2

  AST_PHASE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (int'(load_phase) == (int'($past(load_phase)) + BPW) % 3)); // R5

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=>
      (load_idx == IDX_W'(int'($past(load_idx)) + pal_pkg::commits_per_word(int'($past(load_phase)), BPW)))); // R6

  AST_COMMIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |-> ($countones(commit_vld) == pal_pkg::commits_per_word(int'(load_phase), BPW))); // R6

  AST_NO_STRAY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |-> (commit_vld == '0)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(load_idx) && $stable(load_phase))); // R5

endmodule

bind pal_loader_top pal_loader_chk #(
  .DATA_W  (DATA_W),
  .COMP_W  (COMP_W),
  .IDX_W   (IDX_W),
  .NCOMMIT (NCOMMIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .load_idx   (load_idx),
  .load_phase (load_phase),
  .commit_vld (commit_vld)
);

// File: tb/tb_pal_loader_top.sv
module tb_pal_loader_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        wr_sel;
  logic [31:0] wr_data;
  logic [7:0]  lk_idx;
  logic [23:0] lk_rgb;

  int checks;
  int errors;
  logic [23:0] exp_mem [256];

  pal_loader_top dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .lk_idx  (lk_idx),
    .lk_rgb  (lk_rgb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Component c (0 red, 1 green, 2 blue) of entry e for a given salt.
  function automatic logic [7:0] pb(input int e, input int c, input int salt);
    return 8'((e * 7) + (c * 85) + (salt * 31) + (e >> 3) + (c * e));
  endfunction

  function automatic logic [23:0] pat(input int e, input int salt);
    return {pb(e, 0, salt), pb(e, 1, salt), pb(e, 2, salt)};
  endfunction

  // Word w of the stream that begins with red of entry first; first byte in 31:24.
  function automatic logic [31:0] word_of(input int first, input int w, input int salt);
    logic [31:0] v;
    v = '0;
    for (int b = 0; b < 4; b++) begin
      int k;
      k = 4 * w + b;
      v[31-8*b -: 8] = pb((first + k / 3) % 256, k % 3, salt);
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  // nwords data words starting at entry first; record entries whose blue byte went out.
  task automatic stream(input int first, input int nwords, input int salt);
    for (int w = 0; w < nwords; w++) bus_write(1'b1, word_of(first, w, salt));
    for (int j = 0; 3 * j + 2 < 4 * nwords; j++) exp_mem[(first + j) % 256] = pat((first + j) % 256, salt);
  endtask

  task automatic look(input int idx, input string tag);
    @(negedge clk);
    lk_idx = 8'(idx);
    @(negedge clk);
    chk(tag, lk_rgb, exp_mem[idx]);
  endtask

  // Back-to-back lookups: each negedge checks the index set one cycle before.
  task automatic sweep(input string tag);
    @(negedge clk);
    lk_idx = 8'd0;
    for (int i = 1; i <= 256; i++) begin
      @(negedge clk);
      chk(tag, lk_rgb, exp_mem[i-1]);
      if (i < 256) lk_idx = 8'(i);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected run to complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] old_v;
    checks  = 0;
    errors  = 0;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_sel  = 1'b0;
    wr_data = '0;
    lk_idx  = '0;
    repeat (3) @(negedge clk);
    chk("R1 lookup output zero in reset", lk_rgb, 24'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: stream with no index write starts at entry 0, red first.
    stream(0, 3, 1);
    for (int e = 0; e < 4; e++) look(e, "R1 stream after reset lands at entry 0");

    // R3 R4 R5 R6: whole table as one stream of 192 words from index 0.
    bus_write(1'b0, 32'd0);
    stream(0, 192, 2);
    sweep("R3 R4 R5 R7 full table byte and component order");

    // R6: the stream continues past 255 and wraps to entry 0.
    stream(0, 3, 3);
    for (int e = 0; e < 5; e++) look(e, "R6 index wraps 255 to 0");
    look(255, "R6 entry 255 untouched by wrap");

    // R2: one word then index rewrite: held red byte of entry 133 discarded.
    bus_write(1'b0, 32'd132);
    stream(132, 1, 4);
    bus_write(1'b0, 32'd200);
    stream(200, 3, 5);
    look(132, "R2 entry completed before index write");
    look(133, "R2 held red discarded, entry unchanged");
    for (int e = 200; e < 204; e++) look(e, "R2 phase restarts at red after index write");

    // R2 R5: two words leave red+green of entry 138 held; index rewrite drops them.
    bus_write(1'b0, 32'd136);
    stream(136, 2, 6);
    bus_write(1'b0, 32'd140);
    stream(140, 3, 7);
    for (int e = 136; e < 144; e++) look(e, "R2 R5 partial group then new group");

    // R5: high-index group with distinct salt spans words correctly.
    bus_write(1'b0, 32'd252);
    stream(252, 3, 8);
    for (int e = 252; e < 256; e++) look(e, "R5 entry straddling words");
    look(0, "R6 group at 252 does not spill into entry 0");

    // R8: lookup of entry 63 in the same cycle its blue byte arrives.
    old_v = exp_mem[63];
    bus_write(1'b0, 32'd60);
    bus_write(1'b1, word_of(60, 0, 9));
    bus_write(1'b1, word_of(60, 1, 9));
    @(negedge clk);
    wr_en   = 1'b1;
    wr_sel  = 1'b1;
    wr_data = word_of(60, 2, 9);
    lk_idx  = 8'd63;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    @(negedge clk);
    chk("R8 same-cycle lookup returns old value", lk_rgb, old_v);
    for (int e = 60; e < 64; e++) exp_mem[e] = pat(e, 9);
    @(negedge clk);
    chk("R8 next lookup returns new value", lk_rgb, exp_mem[63]);

    // R7: final back-to-back sweep of the whole table.
    sweep("R7 lookup one cycle latency");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule